// File: doc/BRIEF.md
# Masked Packed Unsigned Minimum Unit

This block is a SIMD datapath stage that takes two 512-bit source vectors and the prior contents of a destination vector. It returns, lane by lane, the smaller of two unsigned integers. Lanes are 32 or 64 bits wide. The active vector length is 128, 256 or 512 bits. One of three forms governs the source of the first operand, the use of the write mask and the treatment of the destination bits above the active length.

In the masked form, a per-lane write mask picks which lanes are computed. A disabled lane either keeps its prior destination value or is cleared. A broadcast option replaces every second-operand lane with the lowest element of source two. The full 512-bit result is registered and qualified by a valid flag one clock after the operation is presented. Reserved control encodings produce the prior destination unchanged.

Top module: `vec_umin_unit`

## Requirements
- R1: Each computed lane holds the source-one lane if that lane is strictly less than the source-two lane as an unsigned number. Otherwise it holds the source-two lane.
- R2: `lane_wide`=0 selects 32-bit lanes, and lane j occupies bits 32j+31:32j. `lane_wide`=1 selects 64-bit lanes, and lane j occupies bits 64j+63:64j. Only the masked form honours `lane_wide`.
- R3: `vlen_sel` 0, 1 and 2 give an active length of 128, 256 and 512 bits. In the clear form (`form_sel`=1) and the masked form (`form_sel`=2), result bits at or above the active length are zero.
- R4: The keep-upper form (`form_sel`=0) uses `dest_old` as source one and ignores `src_a`. It uses 32-bit lanes over bits 127:0 and computes every lane. It passes `dest_old[511:128]` through unchanged. `vlen_sel`, `lane_wide`, `wmask`, `zero_mode` and `bcast_en` have no effect in this form.
- R5: The clear form computes every active lane with 32-bit lanes and ignores `wmask` and `zero_mode`.
- R6: In the masked form, lane j is computed only when `wmask[j]` is 1. A lane with mask bit 0 keeps `dest_old` when `zero_mode`=0 and becomes zero when `zero_mode`=1.
- R7: In the masked form, bits of `wmask` at or above the active lane count have no effect.
- R8: With `bcast_en`=1 in the masked form, every lane compares against `src_b` bits 31:0 (32-bit lanes) or 63:0 (64-bit lanes). The other forms ignore `bcast_en`.
- R9: These encodings are reserved: `form_sel`=3; `vlen_sel`=3 in the clear or masked form; and, in the clear form, `lane_wide`=1 or `vlen_sel`=2. For a reserved encoding the result equals `dest_old` and is still flagged valid.
- R10: An operation presented with `in_valid`=1 at a rising edge gives `out_valid`=1 and its result on `out_data` after that edge. `out_valid` is 0 after an edge without `in_valid`, and `out_data` then holds its value. Synchronous `rst` clears both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| lane_wide | input | 1 | 0: 32-bit lanes, 1: 64-bit lanes |
| vlen_sel | input | 2 | Active length: 0=128, 1=256, 2=512, 3 reserved |
| form_sel | input | 2 | 0 keep-upper, 1 clear, 2 masked, 3 reserved |
| zero_mode | input | 1 | Masked-off lanes: 0 keep, 1 clear |
| bcast_en | input | 1 | Broadcast lowest source-two element |
| wmask | input | 16 | Per-lane write mask, bit j for lane j |
| src_a | input | 512 | Source one vector |
| src_b | input | 512 | Source two vector |
| dest_old | input | 512 | Prior destination contents |
| out_valid | output | 1 | Result valid |
| out_data | output | 512 | Registered result vector |

## Verification
Write masking and broadcast can act on the same operation. A disabled lane then must show the prior or zero value while an enabled neighbour compares against the broadcast element. Operations with a scattered mask, broadcast on and both lane sizes provoke this case, together with the zeroing above the active length. A scoreboard model computes each lane from the stated rules and compares the whole 512-bit word in the cycle after issue. Streams of back-to-back operations also check that no result leaks into the next one.

// File: rtl/vumin_pkg.sv
package vumin_pkg;

    parameter int VEC_W     = 512;
    parameter int ELEM_W    = 32;
    parameter int NCHUNK    = VEC_W / ELEM_W;
    parameter int NWIDE     = NCHUNK / 2;
    parameter int MASK_W    = NCHUNK;
    parameter int LEGACY_W  = 128;
    parameter int LEGACY_CH = LEGACY_W / ELEM_W;
    parameter int CNT_W     = $clog2(NCHUNK) + 2;

    typedef enum logic [1:0] {
        FORM_KEEP_UPPER  = 2'd0,
        FORM_CLEAR_UPPER = 2'd1,
        FORM_MASKED      = 2'd2,
        FORM_RSVD        = 2'd3
    } form_e;

    typedef enum logic [1:0] {
        VL_128  = 2'd0,
        VL_256  = 2'd1,
        VL_512  = 2'd2,
        VL_RSVD = 2'd3
    } vlen_e;

    typedef enum logic [1:0] {
        CH_MIN  = 2'd0,
        CH_KEEP = 2'd1,
        CH_ZERO = 2'd2
    } chunk_act_e;

    typedef struct packed {
        logic wide;
        logic bcast;
        logic src1_from_dest;
    } op_cfg_t;

    // Action for one 32-bit chunk of the result.
    function automatic chunk_act_e chunk_decide(
        input logic rsvd,
        input logic beyond,
        input logic keep_upper,
        input logic masked,
        input logic lane_en,
        input logic zero_off
    );
        chunk_act_e act;
        if (rsvd)
            act = CH_KEEP;
        else if (beyond)
            act = keep_upper ? CH_KEEP : CH_ZERO;
        else if (masked && !lane_en)
            act = zero_off ? CH_ZERO : CH_KEEP;
        else
            act = CH_MIN;
        return act;
    endfunction

endpackage

// File: rtl/vumin_lane_cmp.sv
module vumin_lane_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] y_out
);
    logic a_lt_b;

    always_comb begin
        a_lt_b = (a_in < b_in);
        y_out  = a_lt_b ? a_in : b_in;
    end
endmodule

// File: rtl/vumin_ctrl.sv
module vumin_ctrl
    import vumin_pkg::*;
(
    input  logic [1:0]        form_sel,
    input  logic [1:0]        vlen_sel,
    input  logic              lane_wide,
    input  logic              bcast_en,
    input  logic              zero_mode,
    input  logic [MASK_W-1:0] wmask,
    output op_cfg_t           cfg,
    output chunk_act_e [NCHUNK-1:0] act_vec
);
    form_e            form;
    vlen_e            vlen_req;
    vlen_e            vlen_eff;
    logic             rsvd;
    logic             keep_upper;
    logic             masked;
    logic             wide_eff;
    logic [CNT_W-1:0] active_ch;

    always_comb begin
        form       = form_e'(form_sel);
        vlen_req   = vlen_e'(vlen_sel);
        keep_upper = (form == FORM_KEEP_UPPER);
        masked     = (form == FORM_MASKED);
        rsvd       = (form == FORM_RSVD)
                   || (!keep_upper && vlen_req == VL_RSVD)
                   || (form == FORM_CLEAR_UPPER && (lane_wide || vlen_req == VL_512));
        vlen_eff   = keep_upper ? VL_128 : vlen_req;
        wide_eff   = masked && lane_wide;
        active_ch  = CNT_W'(LEGACY_CH) << vlen_eff;

        cfg.wide           = wide_eff;
        cfg.bcast          = masked && bcast_en && !rsvd;
        cfg.src1_from_dest = keep_upper;
    end

    for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
        logic lane_en;
        logic beyond;
        assign lane_en = wide_eff ? wmask[c/2] : wmask[c];
        assign beyond  = (CNT_W'(c) >= active_ch);
        assign act_vec[c] = chunk_decide(rsvd, beyond, keep_upper, masked,
                                         lane_en, zero_mode);
    end
endmodule

// File: rtl/vumin_operand.sv
module vumin_operand
    import vumin_pkg::*;
(
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic [VEC_W-1:0] dest_old,
    input  op_cfg_t          cfg,
    output logic [VEC_W-1:0] op1,
    output logic [VEC_W-1:0] op2
);
    assign op1 = cfg.src1_from_dest ? dest_old : src_a;

    for (genvar c = 0; c < NCHUNK; c++) begin : g_op2
        logic [ELEM_W-1:0] bc_elem;
        // In wide mode odd chunks take the upper half of the 64-bit element.
        assign bc_elem = (cfg.wide && (c % 2 == 1)) ? src_b[2*ELEM_W-1:ELEM_W]
                                                    : src_b[ELEM_W-1:0];
        assign op2[c*ELEM_W +: ELEM_W] = cfg.bcast ? bc_elem
                                                   : src_b[c*ELEM_W +: ELEM_W];
    end
endmodule

// File: rtl/vec_umin_unit.sv
module vec_umin_unit
    import vumin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              lane_wide,
    input  logic [1:0]        vlen_sel,
    input  logic [1:0]        form_sel,
    input  logic              zero_mode,
    input  logic              bcast_en,
    input  logic [15:0]       wmask,
    input  logic [511:0]      src_a,
    input  logic [511:0]      src_b,
    input  logic [511:0]      dest_old,
    output logic              out_valid,
    output logic [511:0]      out_data
);
    op_cfg_t                 cfg;
    chunk_act_e [NCHUNK-1:0] act_vec;
    logic [VEC_W-1:0]        op1;
    logic [VEC_W-1:0]        op2;
    logic [VEC_W-1:0]        result;
    logic [ELEM_W-1:0]       narrow_y [NCHUNK];
    logic [2*ELEM_W-1:0]     wide_y   [NWIDE];

    vumin_ctrl u_ctrl (
        .form_sel  (form_sel),
        .vlen_sel  (vlen_sel),
        .lane_wide (lane_wide),
        .bcast_en  (bcast_en),
        .zero_mode (zero_mode),
        .wmask     (wmask),
        .cfg       (cfg),
        .act_vec   (act_vec)
    );

    vumin_operand u_operand (
        .src_a    (src_a),
        .src_b    (src_b),
        .dest_old (dest_old),
        .cfg      (cfg),
        .op1      (op1),
        .op2      (op2)
    );

    for (genvar n = 0; n < NCHUNK; n++) begin : g_narrow
        vumin_lane_cmp #(.W(ELEM_W)) u_cmp (
            .a_in  (op1[n*ELEM_W +: ELEM_W]),
            .b_in  (op2[n*ELEM_W +: ELEM_W]),
            .y_out (narrow_y[n])
        );
    end

    for (genvar w = 0; w < NWIDE; w++) begin : g_wide
        vumin_lane_cmp #(.W(2*ELEM_W)) u_cmp (
            .a_in  (op1[w*2*ELEM_W +: 2*ELEM_W]),
            .b_in  (op2[w*2*ELEM_W +: 2*ELEM_W]),
            .y_out (wide_y[w])
        );
    end

    for (genvar c = 0; c < NCHUNK; c++) begin : g_sel
        logic [ELEM_W-1:0] min_ch;
        assign min_ch = cfg.wide ? wide_y[c/2][(c%2)*ELEM_W +: ELEM_W]
                                 : narrow_y[c];
        always_comb begin
            unique case (act_vec[c])
                CH_MIN:  result[c*ELEM_W +: ELEM_W] = min_ch;
                CH_KEEP: result[c*ELEM_W +: ELEM_W] = dest_old[c*ELEM_W +: ELEM_W];
                default: result[c*ELEM_W +: ELEM_W] = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_data <= result;
        end
    end
endmodule

// File: rtl/vumin_chk.sv
module vumin_chk (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         lane_wide,
    input logic [1:0]   vlen_sel,
    input logic [1:0]   form_sel,
    input logic         zero_mode,
    input logic [15:0]  wmask,
    input logic [511:0] src_a,
    input logic [511:0] src_b,
    input logic [511:0] dest_old,
    input logic         out_valid,
    input logic [511:0] out_data
);
    assert_valid_latency_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_data)));

    assert_keep_upper_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && form_sel == 2'd0) |=> out_data[511:128] == $past(dest_old[511:128]));

    assert_rsvd_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && form_sel == 2'd3) |=> out_data == $past(dest_old));

    assert_clear_tail_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && form_sel == 2'd1 && !lane_wide && vlen_sel == 2'd0)
        |=> out_data[511:128] == '0);

    assert_all_off_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && form_sel == 2'd2 && zero_mode && wmask == 16'h0 && vlen_sel != 2'd3)
        |=> out_data == '0);

    assert_min_bound_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && form_sel == 2'd1 && !lane_wide && vlen_sel != 2'd3 && vlen_sel != 2'd2)
        |=> (out_data[31:0] <= $past(src_a[31:0]) && out_data[31:0] <= $past(src_b[31:0])));
endmodule

bind vec_umin_unit vumin_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .lane_wide (lane_wide),
    .vlen_sel  (vlen_sel),
    .form_sel  (form_sel),
    .zero_mode (zero_mode),
    .wmask     (wmask),
    .src_a     (src_a),
    .src_b     (src_b),
    .dest_old  (dest_old),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/sim_vec_umin_unit.sv
`timescale 1ns/1ps
module sim_vec_umin_unit;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         lane_wide = 1'b0;
    logic [1:0]   vlen_sel = 2'd0;
    logic [1:0]   form_sel = 2'd0;
    logic         zero_mode = 1'b0;
    logic         bcast_en = 1'b0;
    logic [15:0]  wmask = 16'h0;
    logic [511:0] src_a = '0;
    logic [511:0] src_b = '0;
    logic [511:0] dest_old = '0;
    logic         out_valid;
    logic [511:0] out_data;

    typedef struct {
        logic [511:0] exp;
        string        tag;
    } item_t;

    item_t        sb_q[$];
    int           n_checks = 0;
    int           n_fails  = 0;
    logic         done = 1'b0;
    logic [511:0] last_exp = '0;

    always #2 clk = ~clk;

    vec_umin_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .lane_wide(lane_wide),
        .vlen_sel(vlen_sel), .form_sel(form_sel), .zero_mode(zero_mode),
        .bcast_en(bcast_en), .wmask(wmask), .src_a(src_a), .src_b(src_b),
        .dest_old(dest_old), .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(input logic ok, input string tag,
                         input logic [511:0] act, input logic [511:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [511:0] pattern(input int seed);
        logic [511:0] v;
        for (int k = 0; k < 16; k++)
            v[k*32 +: 32] = (32'(seed) * 32'h9E3779B9) ^ (32'(k) * 32'h01000193)
                            ^ ((k % 3 == 0) ? 32'h8000_0000 : 32'h0);
        return v;
    endfunction

    function automatic logic [511:0] model(
        input logic wide, input logic [1:0] vl, input logic [1:0] form,
        input logic zm, input logic bc, input logic [15:0] m,
        input logic [511:0] a, input logic [511:0] b, input logic [511:0] d);
        logic [511:0] r;
        logic [63:0]  x, y;
        logic [31:0]  p, q;
        int           bits, kl;
        if (form == 2'd3 || (form != 2'd0 && vl == 2'd3) ||
            (form == 2'd1 && (wide || vl == 2'd2)))
            return d;
        if (form == 2'd0) begin
            r = d;
            for (int j = 0; j < 4; j++) begin
                p = d[j*32 +: 32];
                q = b[j*32 +: 32];
                r[j*32 +: 32] = (p < q) ? p : q;
            end
            return r;
        end
        r    = '0;
        bits = 128 << vl;
        if (form == 2'd2 && wide) begin
            kl = bits / 64;
            for (int j = 0; j < kl; j++) begin
                x = a[j*64 +: 64];
                y = bc ? b[63:0] : b[j*64 +: 64];
                if (m[j]) r[j*64 +: 64] = (x < y) ? x : y;
                else      r[j*64 +: 64] = zm ? 64'h0 : d[j*64 +: 64];
            end
        end else begin
            kl = bits / 32;
            for (int j = 0; j < kl; j++) begin
                p = a[j*32 +: 32];
                q = (form == 2'd2 && bc) ? b[31:0] : b[j*32 +: 32];
                if (form == 2'd1 || m[j]) r[j*32 +: 32] = (p < q) ? p : q;
                else                      r[j*32 +: 32] = zm ? 32'h0 : d[j*32 +: 32];
            end
        end
        return r;
    endfunction

    // Driver: presents one operation and queues its expected result.
    task automatic issue(input string tag, input logic wide, input logic [1:0] vl,
                         input logic [1:0] form, input logic zm, input logic bc,
                         input logic [15:0] m, input logic [511:0] a,
                         input logic [511:0] b, input logic [511:0] d);
        item_t it;
        @(negedge clk);
        lane_wide = wide; vlen_sel = vl; form_sel = form; zero_mode = zm;
        bcast_en = bc; wmask = m; src_a = a; src_b = b; dest_old = d;
        in_valid = 1'b1;
        it.exp = model(wide, vl, form, zm, bc, m, a, b, d);
        it.tag = tag;
        last_exp = it.exp;
        sb_q.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        src_a = pattern(99); src_b = pattern(98); dest_old = pattern(97);
    endtask

    // Monitor: compares each valid result against the scoreboard head.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R10 unexpected out_valid", out_data, '0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(out_data == it.exp, it.tag, out_data, it.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [511:0] a, b, d, eqv;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R10 reset out_valid", {511'b0, out_valid}, '0);
        check(out_data == '0, "R10 reset out_data", out_data, '0);
        rst = 1'b0;

        a = pattern(1); b = pattern(2); d = pattern(3);
        // R4: stray controls and src_a do not matter in keep-upper form
        issue("R4 keep-upper with stray controls", 1'b1, 2'd2, 2'd0, 1'b1, 1'b1, 16'h0,
              pattern(77), b, d);
        issue("R5 clear 128 mask ignored", 1'b0, 2'd0, 2'd1, 1'b1, 1'b0, 16'h0, a, b, d);
        issue("R3 clear 256 tail zero", 1'b0, 2'd1, 2'd1, 1'b0, 1'b0, 16'h1234, a, b, d);
        issue("R9 clear wide reserved", 1'b1, 2'd0, 2'd1, 1'b0, 1'b0, 16'hFFFF, a, b, d);
        issue("R9 clear 512 reserved", 1'b0, 2'd2, 2'd1, 1'b0, 1'b0, 16'hFFFF, a, b, d);
        issue("R9 form 3 reserved", 1'b0, 2'd2, 2'd3, 1'b0, 1'b0, 16'hFFFF, a, b, d);
        issue("R9 masked vlen 3 reserved", 1'b0, 2'd3, 2'd2, 1'b1, 1'b0, 16'hFFFF, a, b, d);
        issue("R6 masked merge 32", 1'b0, 2'd2, 2'd2, 1'b0, 1'b0, 16'hA5C3, a, b, d);
        issue("R6 masked zero 32", 1'b0, 2'd2, 2'd2, 1'b1, 1'b0, 16'hA5C3, a, b, d);
        issue("R2 masked merge 64", 1'b1, 2'd2, 2'd2, 1'b0, 1'b0, 16'h005A, a, b, d);
        idle();
        issue("R7 high mask bits ignored", 1'b0, 2'd0, 2'd2, 1'b0, 1'b0, 16'hFFF5, a, b, d);
        issue("R7 high mask bits ignored 64", 1'b1, 2'd1, 2'd2, 1'b1, 1'b0, 16'hFFF6, a, b, d);
        issue("R8 broadcast 32 with mask", 1'b0, 2'd1, 2'd2, 1'b1, 1'b1, 16'hFF3C, a, b, d);
        issue("R8 broadcast 64 with mask", 1'b1, 2'd2, 2'd2, 1'b1, 1'b1, 16'h003C, a, b, d);
        issue("R8 broadcast ignored in clear", 1'b0, 2'd1, 2'd1, 1'b0, 1'b1, 16'h0, a, b, d);
        issue("R3 masked 64 at 128", 1'b1, 2'd0, 2'd2, 1'b0, 1'b0, 16'h00FF, a, b, d);
        // R1: equal lanes, top-bit set versus clear
        eqv = '0;
        for (int k = 0; k < 16; k++)
            eqv[k*32 +: 32] = (k % 2 == 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
        issue("R1 unsigned top-bit ordering", 1'b0, 2'd2, 2'd2, 1'b0, 1'b0, 16'hFFFF,
              eqv, {eqv[479:0], eqv[511:480]}, d);
        issue("R1 equal lanes", 1'b1, 2'd2, 2'd2, 1'b0, 1'b0, 16'h00FF, eqv, eqv, d);
        issue("R1 keep-upper min pattern", 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 16'h0,
              a, pattern(5), pattern(6));
        idle();
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R10 idle out_valid low", {511'b0, out_valid}, '0);
        check(out_data == last_exp, "R10 idle out_data held", out_data, last_exp);
        check(sb_q.size() == 0, "R10 all results seen", 512'(sb_q.size()), '0);

        issue("R10 before reset", 1'b0, 2'd2, 2'd2, 1'b0, 1'b0, 16'hFFFF, a, b, d);
        idle();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(out_valid == 1'b0, "R10 mid reset out_valid", {511'b0, out_valid}, '0);
        check(out_data == '0, "R10 mid reset out_data", out_data, '0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule